// File: doc/BRIEF.md
# Block Lock Guard

This block keeps a small lock register for each of the eight 64 KB blocks of a flash device and decides, for every access to the array, whether that access may go ahead. Each register carries three live bits: one that bars array reads, one that bars program and erase, and a freeze bit. Once the freeze bit is set, the register cannot be changed again until the next reset. Two protect pins sit on top of the registers. One bars writes to the top block, which holds the boot code. The other bars writes to every other block. In both cases the register contents do not matter.

The host sends one command at a time on a valid/ready pair. A command is an array read, a program, an erase, a lock-register write or a lock-register read, and it carries a byte address and data. A small control state machine has three states: ST_IDLE, ST_EVAL and ST_RESP. It accepts the command in ST_IDLE, with transition T_ACCEPT. It moves to ST_EVAL, where the decision and any register update are made, and from there goes unconditionally to ST_RESP with transition T_DECIDE. ST_RESP presents the one-cycle response and returns to ST_IDLE with transition T_DONE. Two active-low reset inputs are combined, so either one resets the whole block. Address decoding and the array itself belong to the neighbours.

Top module: `blk_lock_guard`

## Requirements
- R1: A lock register has write-lock at bit 0, lock-down (freeze) at bit 1 and read-lock at bit 2. Bits 7:3 are ignored on a write and always read as 0.
- R2: Out of reset, every register reads 01h, `cmd_ready` is 1 and `rsp_valid` is 0.
- R3: A set write-lock bit denies program (kind 1) and erase (kind 2) to its block. A set read-lock bit denies array reads (kind 0) to its block.
- R4: While a block's lock-down bit is set, a register write (kind 3) to that block changes no bit and responds with `rsp_allow`=0. Lock-down cannot be cleared by a write.
- R5: A low level on either `rst_a_n` or `rst_b_n` returns every register, lock-down included, to 01h.
- R6: While `top_lock_n` is 0, program and erase to block 7 are denied, whatever its register holds.
- R7: While `wr_prot_n` is 0, program and erase to blocks 0 to 6 are denied. Block 7 is not affected by this pin, and neither pin affects array reads.
- R8: The block index is taken from `cmd_addr[18:16]`. It selects the register for every command kind.
- R9: A denied array read returns 00h on `rsp_data`, and an allowed one returns the `arr_rdata` value sampled when the command was accepted. A denied program or erase raises `rsp_viol` for the single response cycle.
- R10: A command is taken when `cmd_valid` and `cmd_ready` are both high. The response appears exactly two cycles later and lasts one cycle. A register read (kind 4) returns the register in `rsp_data` with `rsp_allow`=1, and kinds 5 to 7 are answered with `rsp_allow`=0 and no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_a_n | input | 1 | Active-low reset, first source |
| rst_b_n | input | 1 | Active-low reset, second source |
| top_lock_n | input | 1 | Low: top block write protected |
| wr_prot_n | input | 1 | Low: all other blocks write protected |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_kind | input | 3 | 0 read, 1 program, 2 erase, 3 reg write, 4 reg read |
| cmd_addr | input | 19 | Byte address, top bits select the block |
| cmd_wdata | input | 8 | Register write data |
| arr_rdata | input | 8 | Array data for the read being checked |
| rsp_valid | output | 1 | Response cycle |
| rsp_allow | output | 1 | Access granted or register write applied |
| rsp_viol | output | 1 | Denied program or erase |
| rsp_data | output | 8 | Read data, register value or 00h |

## Verification
The bench targets the freeze bit. It attempts both a change and a clear after freezing, and a design that let a frozen register change would read back a new value. Each pin is exercised against the block the other pin guards, which exposes a swapped top-block comparison as a wrong grant. A register loaded with a value whose reserved bits are set is read back, and a design that stored those bits would return more than 04h. Each reset input is pulsed alone, and a design that honoured only one of them would keep the frozen value. Denied reads are given nonzero array data, so any leak of that data shows in the response.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

    typedef enum logic [2:0] {
        K_ARR_RD = 3'd0,
        K_PROG   = 3'd1,
        K_ERASE  = 3'd2,
        K_REG_WR = 3'd3,
        K_REG_RD = 3'd4
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_RESP = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic rd_lock;
        logic lk_down;
        logic wr_lock;
    } lock_bits_t;

    localparam lock_bits_t LOCK_RESET = 3'b001;

endpackage

// File: rtl/lock_bank.sv
module lock_bank
    import blk_lock_pkg::*;
#(
    parameter int NBLK  = 8,
    parameter int BLK_W = $clog2(NBLK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [BLK_W-1:0]       wr_blk,
    input  lock_bits_t             wr_bits,
    output lock_bits_t [NBLK-1:0]  locks_o
);

    generate
        for (genvar i = 0; i < NBLK; i++) begin : g_blk
            lock_bits_t q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= LOCK_RESET;
                end else if (wr_en && (wr_blk == BLK_W'(i)) && !q.lk_down) begin
                    q <= wr_bits;
                end
            end

            assign locks_o[i] = q;

            // R4: a frozen register never changes until reset
            p_frozen_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
                q.lk_down |=> (q.lk_down && $stable(q.rd_lock) && $stable(q.wr_lock)));
        end
    endgenerate

endmodule

// File: rtl/prot_eval.sv
module prot_eval
    import blk_lock_pkg::*;
#(
    parameter int NBLK  = 8,
    parameter int BLK_W = $clog2(NBLK)
) (
    input  cmd_kind_e              kind,
    input  logic [BLK_W-1:0]       blk,
    input  lock_bits_t [NBLK-1:0]  locks,
    input  logic                   top_lock_n,
    input  logic                   wr_prot_n,
    output lock_bits_t             cur,
    output logic                   allow,
    output logic                   viol
);

    localparam logic [BLK_W-1:0] TOP_BLK = BLK_W'(NBLK - 1);

    logic pin_block;

    always_comb begin
        cur       = locks[blk];
        pin_block = (blk == TOP_BLK) ? !top_lock_n : !wr_prot_n;
        allow     = 1'b0;
        viol      = 1'b0;
        case (kind)
            K_ARR_RD: allow = !cur.rd_lock;
            K_PROG, K_ERASE: begin
                allow = !cur.wr_lock && !pin_block;
                viol  = !allow;
            end
            K_REG_WR: allow = !cur.lk_down;
            K_REG_RD: allow = 1'b1;
            default:  allow = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctrl_fsm.sv
module ctrl_fsm
    import blk_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    output logic cmd_ready,
    output logic accept,
    output logic eval_fire,
    output logic resp_phase
);

    ctl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_d = ST_EVAL;  // T_ACCEPT
            ST_EVAL: state_d = ST_RESP;                 // T_DECIDE
            ST_RESP: state_d = ST_IDLE;                 // T_DONE
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_ready  = (state_q == ST_IDLE);
        accept     = cmd_ready && cmd_valid;
        eval_fire  = (state_q == ST_EVAL);
        resp_phase = (state_q == ST_RESP);
    end

    // R10: evaluation follows acceptance by one cycle
    p_eval_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> eval_fire);
    // R10: response lasts a single cycle, then the block is ready again
    p_resp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_phase |=> cmd_ready);

endmodule

// File: rtl/blk_lock_guard.sv
module blk_lock_guard
    import blk_lock_pkg::*;
#(
    parameter int NBLK   = 8,
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_a_n,
    input  logic              rst_b_n,
    input  logic              top_lock_n,
    input  logic              wr_prot_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic              rsp_viol,
    output logic [DATA_W-1:0] rsp_data
);

    localparam int BLK_W = $clog2(NBLK);
    localparam logic [BLK_W-1:0] TOP_BLK = BLK_W'(NBLK - 1);

    logic rst_n;
    assign rst_n = rst_a_n & rst_b_n;

    logic accept, eval_fire, resp_phase;

    ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .accept     (accept),
        .eval_fire  (eval_fire),
        .resp_phase (resp_phase)
    );

    cmd_kind_e         kind_q;
    logic [BLK_W-1:0]  blk_q;
    lock_bits_t        wbits_q;
    logic [DATA_W-1:0] arr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_ARR_RD;
            blk_q   <= '0;
            wbits_q <= '0;
            arr_q   <= '0;
        end else if (accept) begin
            kind_q  <= cmd_kind_e'(cmd_kind);
            blk_q   <= cmd_addr[ADDR_W-1 -: BLK_W];
            wbits_q <= lock_bits_t'(cmd_wdata[2:0]);
            arr_q   <= arr_rdata;
        end
    end

    lock_bits_t [NBLK-1:0] locks;
    lock_bits_t            cur;
    logic                  dec_allow, dec_viol;

    lock_bank #(.NBLK(NBLK), .BLK_W(BLK_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (eval_fire && (kind_q == K_REG_WR)),
        .wr_blk  (blk_q),
        .wr_bits (wbits_q),
        .locks_o (locks)
    );

    prot_eval #(.NBLK(NBLK), .BLK_W(BLK_W)) u_eval (
        .kind       (kind_q),
        .blk        (blk_q),
        .locks      (locks),
        .top_lock_n (top_lock_n),
        .wr_prot_n  (wr_prot_n),
        .cur        (cur),
        .allow      (dec_allow),
        .viol       (dec_viol)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_allow <= 1'b0;
            rsp_viol  <= 1'b0;
            rsp_data  <= '0;
        end else if (eval_fire) begin
            rsp_valid <= 1'b1;
            rsp_allow <= dec_allow;
            rsp_viol  <= dec_viol;
            if (kind_q == K_REG_RD)
                rsp_data <= DATA_W'(cur);
            else if (kind_q == K_ARR_RD && dec_allow)
                rsp_data <= arr_q;
            else
                rsp_data <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_allow <= 1'b0;
            rsp_viol  <= 1'b0;
            rsp_data  <= '0;
        end
    end

    // R10: commands must carry known address and data
    p_known_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (!$isunknown(cmd_addr) && !$isunknown(cmd_wdata)));
    // R6: the top-block pin overrides the register
    p_top_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_fire && (kind_q == K_PROG || kind_q == K_ERASE) && blk_q == TOP_BLK && !top_lock_n)
        |=> (rsp_valid && !rsp_allow && rsp_viol));
    // R7: the write-protect pin guards all but the top block
    p_wp_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_fire && (kind_q == K_PROG || kind_q == K_ERASE) && blk_q != TOP_BLK && !wr_prot_n)
        |=> (rsp_valid && !rsp_allow));
    // R9: no data leaks through a denied response
    p_deny_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_allow) |-> (rsp_data == '0));
    // R9: the violation flag is a single-cycle pulse on a denied response
    p_viol_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_viol |-> (rsp_valid && !rsp_allow) ##1 !rsp_viol);

endmodule

// File: tb/sim_blk_lock_guard.sv
module sim_blk_lock_guard;

    logic       clk = 1'b0;
    logic       rst_a_n, rst_b_n, top_lock_n, wr_prot_n;
    logic       cmd_valid, cmd_ready;
    logic [2:0] cmd_kind;
    logic [18:0] cmd_addr;
    logic [7:0] cmd_wdata, arr_rdata;
    logic       rsp_valid, rsp_allow, rsp_viol;
    logic [7:0] rsp_data;

    int n_chk = 0;
    int n_bad = 0;
    logic g_allow, g_viol;
    logic [7:0] g_data;

    always #4 clk = ~clk;

    blk_lock_guard u0 (
        .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
        .top_lock_n(top_lock_n), .wr_prot_n(wr_prot_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .arr_rdata(arr_rdata),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_viol(rsp_viol),
        .rsp_data(rsp_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one command and capture its response two cycles after acceptance.
    task automatic run_cmd(input logic [2:0] k, input logic [2:0] blk,
                           input logic [7:0] wd, input logic [7:0] ad);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = k; cmd_addr = {blk, 16'h5a3c};
        cmd_wdata = wd; arr_rdata = ad;
        @(negedge clk);
        cmd_valid = 1'b0; arr_rdata = 8'hff;
        @(negedge clk);
        check("R10 response valid", {31'd0, rsp_valid}, 32'd1);
        g_allow = rsp_allow; g_viol = rsp_viol; g_data = rsp_data;
    endtask

    task automatic reg_expect(input logic [2:0] blk, input logic [7:0] exp, input string tag);
        run_cmd(3'd4, blk, 8'h00, 8'h00);
        check(tag, {24'd0, g_data}, {24'd0, exp});
    endtask

    task automatic t_reset_state;
        check("R2 ready after reset", {31'd0, cmd_ready}, 32'd1);
        check("R2 no response after reset", {31'd0, rsp_valid}, 32'd0);
        for (int b = 0; b < 8; b++) reg_expect(3'(b), 8'h01, "R2 reset value");
        @(negedge clk);
        check("R10 response lasts one cycle", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_write_lock;
        run_cmd(3'd1, 3'd2, 8'h00, 8'h00);
        check("R3 program denied by write-lock", {31'd0, g_allow}, 32'd0);
        check("R9 violation on denied program", {31'd0, g_viol}, 32'd1);
        run_cmd(3'd3, 3'd2, 8'h00, 8'h00);
        check("R1 register write applied", {31'd0, g_allow}, 32'd1);
        run_cmd(3'd1, 3'd2, 8'h00, 8'h00);
        check("R3 program allowed when unlocked", {30'd0, g_allow, g_viol}, 32'd2);
        run_cmd(3'd2, 3'd4, 8'h00, 8'h00);
        check("R3 erase denied on other block", {30'd0, g_allow, g_viol}, 32'd1);
    endtask

    task automatic t_read_lock;
        run_cmd(3'd3, 3'd3, 8'hfc, 8'h00);
        reg_expect(3'd3, 8'h04, "R1 reserved bits read zero");
        run_cmd(3'd0, 3'd3, 8'h00, 8'h77);
        check("R3 read denied by read-lock", {31'd0, g_allow}, 32'd0);
        check("R9 denied read returns zero", {24'd0, g_data}, 32'd0);
        run_cmd(3'd0, 3'd2, 8'h00, 8'ha5);
        check("R9 allowed read passes data", {24'd0, g_data}, 32'ha5);
        run_cmd(3'd1, 3'd3, 8'h00, 8'h00);
        check("R8 program on block 3 allowed", {31'd0, g_allow}, 32'd1);
    endtask

    task automatic t_lock_down;
        run_cmd(3'd3, 3'd2, 8'h02, 8'h00);
        reg_expect(3'd2, 8'h02, "R4 lock-down set");
        run_cmd(3'd3, 3'd2, 8'h05, 8'h00);
        check("R4 frozen write reports not applied", {31'd0, g_allow}, 32'd0);
        reg_expect(3'd2, 8'h02, "R4 frozen bits unchanged");
        run_cmd(3'd3, 3'd2, 8'h00, 8'h00);
        reg_expect(3'd2, 8'h02, "R4 lock-down not cleared by write");
        reg_expect(3'd1, 8'h01, "R8 neighbour block untouched");
    endtask

    task automatic t_pins;
        run_cmd(3'd3, 3'd7, 8'h00, 8'h00);
        run_cmd(3'd3, 3'd1, 8'h00, 8'h00);
        top_lock_n = 1'b0;
        run_cmd(3'd1, 3'd7, 8'h00, 8'h00);
        check("R6 top pin denies program", {30'd0, g_allow, g_viol}, 32'd1);
        run_cmd(3'd2, 3'd1, 8'h00, 8'h00);
        check("R6 top pin spares block 1", {31'd0, g_allow}, 32'd1);
        top_lock_n = 1'b1; wr_prot_n = 1'b0;
        run_cmd(3'd2, 3'd1, 8'h00, 8'h00);
        check("R7 protect pin denies erase", {30'd0, g_allow, g_viol}, 32'd1);
        run_cmd(3'd1, 3'd7, 8'h00, 8'h00);
        check("R7 protect pin spares top block", {31'd0, g_allow}, 32'd1);
        run_cmd(3'd0, 3'd1, 8'h00, 8'h3c);
        check("R7 reads unaffected by pin", {24'd0, g_data}, 32'h3c);
        wr_prot_n = 1'b1;
        run_cmd(3'd5, 3'd1, 8'h00, 8'h00);
        check("R10 unknown kind denied", {30'd0, g_allow, g_viol}, 32'd0);
    endtask

    task automatic t_resets;
        @(negedge clk); rst_b_n = 1'b0;
        @(negedge clk); rst_b_n = 1'b1;
        reg_expect(3'd2, 8'h01, "R5 second reset clears lock-down");
        reg_expect(3'd7, 8'h01, "R5 second reset restores block 7");
        run_cmd(3'd3, 3'd5, 8'h06, 8'h00);
        reg_expect(3'd5, 8'h06, "R4 lock-down with read-lock");
        @(negedge clk); rst_a_n = 1'b0;
        @(negedge clk); rst_a_n = 1'b1;
        reg_expect(3'd5, 8'h01, "R5 first reset clears lock-down");
    endtask

    initial begin
        rst_a_n = 1'b0; rst_b_n = 1'b0; top_lock_n = 1'b1; wr_prot_n = 1'b1;
        cmd_valid = 1'b0; cmd_kind = 3'd0; cmd_addr = '0; cmd_wdata = '0; arr_rdata = '0;
        repeat (3) @(negedge clk);
        rst_a_n = 1'b1; rst_b_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_write_lock();
        t_read_lock();
        t_lock_down();
        t_pins();
        t_resets();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule